// File: doc/BRIEF.md
# L1-Side L2 Way-Index Store

This block sits next to an L1 data cache array and keeps, for every L1 line, a short binary number naming the L2 way that holds the copy of that line. It takes the same line address as the L1 data array, and it watches the same write strobe. When the L1 write comes from a line fill after an L1 miss, the way index of the L2 way that supplied the line is stored. When the L1 write comes from a store, the entry is looked up. One clock later the way index goes out toward a downstream buffer, together with a miss flag. Downstream logic uses that flag to enable every L2 way, or only the one way named.

On each cycle the L1 port is decoded into one of three access modes. These modes are the states of the block:
- IDLE: no strobe, which means a load or no access.
- FILL: strobe with the update flag set.
- LOOKUP: strobe with the update flag clear.

Every cycle is a transition into the mode its inputs select, from any mode. Every entry wordline is ANDed with the write strobe, so a load touches no entry. The FILL and LOOKUP modes also act on the entry the address names. Each entry has a valid bit. Reset clears it, and an invalidate issued when L2 evicts the line clears it too. A store to an invalid entry is reported as a miss.

Top module: `waytag_store`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fwd_valid`, `fwd_miss` and `fwd_way` are 0, and every entry is invalid. After reset, a store to any line reports a miss.
- R2: A fill (`l1_wr_en`=1, `fill_upd`=1) writes the entry at `line_addr` and marks it valid. The value written is the label of the single L2 way whose bit is set in the one-hot `fill_src`. The label of way k is binary k: bit 0 gives 0, bit 1 gives 1, bit 2 gives 2, bit 3 gives 3. A later fill overwrites the earlier label.
- R3: A store (`l1_wr_en`=1, `fill_upd`=0) to a valid entry makes `fwd_valid`=1, `fwd_miss`=0 and `fwd_way` equal to the stored label in the cycle after the store.
- R4: A store to an invalid entry makes `fwd_valid`=1, `fwd_miss`=1 and `fwd_way`=0 in the cycle after the store.
- R5: When `l1_wr_en`=0, no entry changes, whatever the value of `fill_upd`. In the next cycle `fwd_valid` is 0 and `fwd_way` and `fwd_miss` keep their values.
- R6: An invalidate (`inv_en`=1) clears the valid bit of entry `inv_addr`. If a fill targets the same line in the same cycle, the invalidate wins and the entry ends invalid.
- R7: A store that looks up the line being invalidated in the same cycle reports the contents that line held before the invalidate.
- R8: Back-to-back stores each produce their own result in the following cycle.
- R9: A fill makes `fwd_valid` 0 in the next cycle and leaves `fwd_way` and `fwd_miss` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l1_wr_en | input | 1 | L1 data-array write strobe |
| fill_upd | input | 1 | Set when the L1 write is a line fill from L2 |
| line_addr | input | LINE_W | L1 line address shared with the data array |
| fill_src | input | L2_WAYS | One-hot L2 way that supplied the filled line |
| inv_en | input | 1 | Invalidate request on an L2 eviction |
| inv_addr | input | LINE_W | L1 line to invalidate |
| fwd_valid | output | 1 | Lookup result present, one cycle after a store |
| fwd_way | output | WAY_W | L2 way index of the stored line (0 on a miss) |
| fwd_miss | output | 1 | No valid way index for the stored line |

## Verification
On every cycle the assertions check the following:
- Each store yields a result one cycle later.
- A load or a fill yields no result, and the held outputs do not move.
- A miss always carries way 0.
- Fill sources are one-hot.
- No entry changes without a wordline or an invalidate.
- An invalidated line reads back as invalid.

Only the bench scenarios can show the rest:
- A label stored by a fill is the one a later store reads back, for each way and every line.
- An invalidate wins over a fill of the same line.
- A same-cycle lookup sees the old contents.
- Reset empties the whole store.

// File: rtl/waytag_pkg.sv
package waytag_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_FILL   = 2'd1,
        ACC_LOOKUP = 2'd2
    } acc_mode_e;
endpackage

// File: rtl/waytag_mode_dec.sv
module waytag_mode_dec
    import waytag_pkg::*;
#(
    parameter int LINES  = 64,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              upd,
    input  logic [LINE_W-1:0] addr,
    output acc_mode_e         mode,
    output logic [LINES-1:0]  wl
);
    always_comb begin
        unique case ({wr_en, upd})
            2'b11:   mode = ACC_FILL;
            2'b10:   mode = ACC_LOOKUP;
            default: mode = ACC_IDLE;
        endcase
    end

    for (genvar i = 0; i < LINES; i++) begin : g_wl
        assign wl[i] = wr_en && (addr == LINE_W'(i));
    end

    // R5: a strobe-less cycle is always decoded as idle
    p_idle_without_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (mode == ACC_IDLE) && ($countones(wl) == 0));
endmodule

// File: rtl/waytag_label_enc.sv
module waytag_label_enc #(
    parameter int L2_WAYS = 4,
    localparam int WAY_W  = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check_en,
    input  logic [L2_WAYS-1:0] src,
    output logic [WAY_W-1:0]   label
);
    // fixed way register: label k is binary k
    logic [L2_WAYS-1:0][WAY_W-1:0] way_reg;
    for (genvar k = 0; k < L2_WAYS; k++) begin : g_reg
        assign way_reg[k] = WAY_W'(k);
    end

    always_comb begin
        label = '0;
        for (int k = 0; k < L2_WAYS; k++) begin
            if (src[k]) label = label | way_reg[k];
        end
    end

    // R2: fill source must name exactly one L2 way
    p_fill_src_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        check_en |-> ($countones(src) == 1));
endmodule

// File: rtl/waytag_array.sv
module waytag_array #(
    parameter int LINES   = 64,
    parameter int L2_WAYS = 4,
    localparam int LINE_W = $clog2(LINES),
    localparam int WAY_W  = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  wl,
    input  logic              do_fill,
    input  logic [WAY_W-1:0]  fill_label,
    input  logic              inv_en,
    input  logic [LINE_W-1:0] inv_addr,
    input  logic [LINE_W-1:0] rd_addr,
    output logic [WAY_W-1:0]  rd_way,
    output logic              rd_valid
);
    logic [LINES-1:0][WAY_W-1:0] way_q;
    logic [LINES-1:0]            valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            way_q   <= '0;
            valid_q <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (inv_en && (inv_addr == LINE_W'(i))) begin
                    valid_q[i] <= 1'b0;
                end else if (wl[i] && do_fill) begin
                    valid_q[i] <= 1'b1;
                    way_q[i]   <= fill_label;
                end
            end
        end
    end

    assign rd_way   = way_q[rd_addr];
    assign rd_valid = valid_q[rd_addr];

    // R5: without a wordline or an invalidate nothing in the store moves
    p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wl == '0) && !inv_en |=> $stable(valid_q) && $stable(way_q));

    // R6: an invalidated line is invalid afterwards
    p_inval_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_q[$past(inv_addr)]);
endmodule

// File: rtl/waytag_store.sv
module waytag_store
    import waytag_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int L2_WAYS = 4,
    localparam int LINE_W = $clog2(LINES),
    localparam int WAY_W  = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               l1_wr_en,
    input  logic               fill_upd,
    input  logic [LINE_W-1:0]  line_addr,
    input  logic [L2_WAYS-1:0] fill_src,
    input  logic               inv_en,
    input  logic [LINE_W-1:0]  inv_addr,
    output logic               fwd_valid,
    output logic [WAY_W-1:0]   fwd_way,
    output logic               fwd_miss
);
    acc_mode_e        mode;
    logic [LINES-1:0] wl;
    logic [WAY_W-1:0] label;
    logic [WAY_W-1:0] rd_way;
    logic             rd_valid;
    logic             is_fill;

    waytag_mode_dec #(.LINES(LINES)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (l1_wr_en),
        .upd   (fill_upd),
        .addr  (line_addr),
        .mode  (mode),
        .wl    (wl)
    );

    assign is_fill = (mode == ACC_FILL);

    waytag_label_enc #(.L2_WAYS(L2_WAYS)) u_lbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .check_en (is_fill),
        .src      (fill_src),
        .label    (label)
    );

    waytag_array #(.LINES(LINES), .L2_WAYS(L2_WAYS)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wl         (wl),
        .do_fill    (is_fill),
        .fill_label (label),
        .inv_en     (inv_en),
        .inv_addr   (inv_addr),
        .rd_addr    (line_addr),
        .rd_way     (rd_way),
        .rd_valid   (rd_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_way   <= '0;
            fwd_miss  <= 1'b0;
        end else begin
            unique case (mode)
                ACC_LOOKUP: begin
                    fwd_valid <= 1'b1;
                    fwd_miss  <= !rd_valid;
                    fwd_way   <= rd_valid ? rd_way : '0;
                end
                default: fwd_valid <= 1'b0;
            endcase
        end
    end

    // R3 / R8: every store yields a result in the next cycle
    p_store_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        l1_wr_en && !fill_upd |=> fwd_valid);

    // R5 / R9: loads and fills yield no result and leave outputs held
    p_no_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(l1_wr_en && !fill_upd) |=> !fwd_valid && $stable(fwd_way) && $stable(fwd_miss));

    // R4: a miss never carries a way index
    p_miss_way_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_miss |-> (fwd_way == '0));
endmodule

// File: tb/tb_waytag_store.sv
module tb_waytag_store;
    localparam int LINES   = 64;
    localparam int L2_WAYS = 4;
    localparam int LINE_W  = 6;
    localparam int WAY_W   = 2;
    localparam int NV      = 20;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               l1_wr_en = 1'b0;
    logic               fill_upd = 1'b0;
    logic [LINE_W-1:0]  line_addr = '0;
    logic [L2_WAYS-1:0] fill_src = '0;
    logic               inv_en = 1'b0;
    logic [LINE_W-1:0]  inv_addr = '0;
    logic               fwd_valid;
    logic [WAY_W-1:0]   fwd_way;
    logic               fwd_miss;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    waytag_store #(.LINES(LINES), .L2_WAYS(L2_WAYS)) dut (
        .clk(clk), .rst_n(rst_n), .l1_wr_en(l1_wr_en), .fill_upd(fill_upd),
        .line_addr(line_addr), .fill_src(fill_src), .inv_en(inv_en),
        .inv_addr(inv_addr), .fwd_valid(fwd_valid), .fwd_way(fwd_way),
        .fwd_miss(fwd_miss)
    );

    always #2 clk = ~clk;

    // fields: wr upd addr src inv iaddr | exp_valid exp_way exp_miss | req
    localparam logic [26:0] VEC [NV] = '{
        {1'b1,1'b0,6'd5, 4'b0000,1'b0,6'd0,  1'b1,2'd0,1'b1, 4'd4}, // R4 store to empty line
        {1'b1,1'b1,6'd5, 4'b0100,1'b0,6'd0,  1'b0,2'd0,1'b1, 4'd9}, // R9 fill holds outputs
        {1'b1,1'b0,6'd5, 4'b0000,1'b0,6'd0,  1'b1,2'd2,1'b0, 4'd3}, // R3 way 2 back
        {1'b1,1'b1,6'd63,4'b1000,1'b0,6'd0,  1'b0,2'd2,1'b0, 4'd2}, // R2 fill top line way 3
        {1'b1,1'b0,6'd63,4'b0000,1'b0,6'd0,  1'b1,2'd3,1'b0, 4'd2}, // R2 way 3 back
        {1'b0,1'b1,6'd63,4'b0001,1'b0,6'd0,  1'b0,2'd3,1'b0, 4'd5}, // R5 gated write
        {1'b1,1'b0,6'd63,4'b0000,1'b0,6'd0,  1'b1,2'd3,1'b0, 4'd5}, // R5 entry unchanged
        {1'b1,1'b1,6'd0, 4'b0001,1'b0,6'd0,  1'b0,2'd3,1'b0, 4'd2}, // R2 fill way 0
        {1'b1,1'b0,6'd0, 4'b0000,1'b0,6'd0,  1'b1,2'd0,1'b0, 4'd2}, // R2 way 0 valid hit
        {1'b1,1'b1,6'd1, 4'b0010,1'b0,6'd0,  1'b0,2'd0,1'b0, 4'd2}, // R2 fill way 1
        {1'b1,1'b0,6'd1, 4'b0000,1'b0,6'd0,  1'b1,2'd1,1'b0, 4'd8}, // R8 first of pair
        {1'b1,1'b0,6'd5, 4'b0000,1'b0,6'd0,  1'b1,2'd2,1'b0, 4'd8}, // R8 second of pair
        {1'b1,1'b0,6'd5, 4'b0000,1'b1,6'd5,  1'b1,2'd2,1'b0, 4'd7}, // R7 old contents
        {1'b1,1'b0,6'd5, 4'b0000,1'b0,6'd0,  1'b1,2'd0,1'b1, 4'd6}, // R6 now invalid
        {1'b1,1'b1,6'd1, 4'b1000,1'b1,6'd1,  1'b0,2'd0,1'b1, 4'd6}, // R6 inval beats fill
        {1'b1,1'b0,6'd1, 4'b0000,1'b0,6'd0,  1'b1,2'd0,1'b1, 4'd6}, // R6 line 1 invalid
        {1'b1,1'b1,6'd0, 4'b0100,1'b0,6'd0,  1'b0,2'd0,1'b1, 4'd2}, // R2 overwrite line 0
        {1'b1,1'b0,6'd0, 4'b0000,1'b0,6'd0,  1'b1,2'd2,1'b0, 4'd2}, // R2 new label
        {1'b0,1'b0,6'd0, 4'b0000,1'b1,6'd63, 1'b0,2'd2,1'b0, 4'd6}, // R6 inval during load
        {1'b1,1'b0,6'd63,4'b0000,1'b0,6'd0,  1'b1,2'd0,1'b1, 4'd6}  // R6 line 63 invalid
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input int ev, input int ew, input int em);
        check(req, "fwd_valid", int'(fwd_valid), ev);
        check(req, "fwd_way", int'(fwd_way), ew);
        check(req, "fwd_miss", int'(fwd_miss), em);
    endtask

    task automatic drive(input logic wr, input logic up, input int a, input logic [3:0] s,
                         input logic iv, input int ia);
        l1_wr_en  = wr;
        fill_upd  = up;
        line_addr = LINE_W'(a);
        fill_src  = s;
        inv_en    = iv;
        inv_addr  = LINE_W'(ia);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_out("R1", 0, 0, 0);               // outputs during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1", 0, 0, 0);               // first cycle after reset

        // table walk: apply at a negedge, inspect at the next negedge
        for (int v = 0; v < NV; v++) begin
            logic [26:0] e;
            string rq;
            e = VEC[v];
            drive(e[26], e[25], int'(e[24:19]), e[18:15], e[14], int'(e[13:8]));
            @(negedge clk);
            rq = $sformatf("R%0d", e[3:0]);
            check_out(rq, int'(e[7]), int'(e[6:5]), int'(e[4]));
        end

        // R2 sweep: fill every line with label i%4, then read each back
        for (int i = 0; i < LINES; i++) begin
            drive(1'b1, 1'b1, i, 4'(1 << (i % 4)), 1'b0, 0);
            @(negedge clk);
        end
        for (int i = 0; i < LINES; i++) begin
            drive(1'b1, 1'b0, i, 4'b0000, 1'b0, 0);
            @(negedge clk);
            check_out("R2", 1, i % 4, 0);
        end

        // R5: a load leaves the last result in place
        drive(1'b0, 1'b0, 7, 4'b0000, 1'b0, 0);
        @(negedge clk);
        check_out("R5", 0, 3, 0);

        // R1: reset mid-run clears outputs and empties every entry
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 1'b0, 2, 4'b0000, 1'b0, 0);
        @(negedge clk);
        check_out("R1", 1, 0, 1);
        drive(1'b1, 1'b0, 63, 4'b0000, 1'b0, 0);
        @(negedge clk);
        check_out("R1", 1, 0, 1);
        drive(1'b0, 1'b0, 0, 4'b0000, 1'b0, 0);
        @(negedge clk);
        finish_run();
    end
endmodule